// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Scoped Invalidation

This block holds a small set of virtual-to-physical page translations. All of its slots are searched in parallel. Each slot records the following:

- a virtual page base and a page-size code;
- a partition number and a context number;
- a flag that marks a real (context-free) translation;
- a lock flag;
- a physical page base.

A lookup port returns its answer combinationally in the cycle it is presented: a hit flag, the winning slot index, the translated physical address and that slot's lock and size fields.

Changes arrive on a command port with a valid/ready handshake, at most one per cycle. The commands are:

- insert a translation;
- drop the pages that cover one address;
- drop every slot of one context;
- drop the unlocked slots of one partition;
- drop everything.

Each accepted command raises a one-cycle flush pulse. A neighbouring fast-path translation cache uses this pulse to discard its own copy of recent results.

The page-size code `c` selects a page of `2^(BASE_SHIFT + SHIFT_STEP*c)` bytes. The slot count is a parameter from 2 to 64; other values stop elaboration.

Top module: `tlb_fa`

## Requirements
- R1: While reset is high, `cmdReady` is 0. From the first clock edge after reset is released it is 1, and no lookup hits until an insert is done.
- R2: A lookup hits a slot when all of these hold: the slot is valid, its partition and real flag equal the key, its context equals the key unless the key is real, and the address lies inside the slot's page. The physical address is then the slot's physical base above the page offset, combined with the lookup address's offset bits.
- R3: When several slots hit, the lowest index wins. Its index, lock flag and size code are the ones output.
- R4: Insert (op code 0) writes the lowest-index invalid slot while one exists. The translation is visible to lookups from the next cycle on.
- R5: When all slots are valid, insert searches circularly from a replacement pointer that is 0 after reset. It writes the first unlocked slot found and moves the pointer to the slot after it. When every slot is locked, the insert changes nothing.
- R6: Page demap (op code 1) invalidates every slot that a lookup with the command's address, partition, real flag and context would hit, locked slots included.
- R7: Context demap (op code 2) invalidates every valid slot whose context and partition both equal the operands, locked or not.
- R8: Partition demap (op code 3) invalidates the slots of the given partition except the locked ones.
- R9: Invalidate-all (op code 4) clears every slot, locked ones included.
- R10: `flushPulse` is 1 for exactly the cycle after each accepted command with op code 0 to 4, and 0 otherwise. Each such command's effect is seen by lookups in that same cycle.
- R11: Op codes 5 to 7 are accepted but change no slot and raise no flush pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be taken |
| cmdOp | input | 3 | Command code (0 insert, 1 page, 2 context, 3 partition, 4 all) |
| cmdVa | input | VA_W | Virtual address operand |
| cmdPart | input | PART_W | Partition operand |
| cmdCtx | input | CTX_W | Context operand |
| cmdReal | input | 1 | Real-translation operand |
| cmdLocked | input | 1 | Lock flag for insert |
| cmdPa | input | PA_W | Physical base for insert |
| cmdSize | input | SZ_W | Page-size code for insert |
| lkVa | input | VA_W | Lookup address |
| lkPart | input | PART_W | Lookup partition |
| lkReal | input | 1 | Lookup is real |
| lkCtx | input | CTX_W | Lookup context |
| lkHit | output | 1 | Lookup matched a slot |
| lkIndex | output | IDX_W | Matching slot |
| lkPa | output | PA_W | Translated address |
| lkLocked | output | 1 | Lock flag of matching slot |
| lkSize | output | SZ_W | Size code of matching slot |
| flushPulse | output | 1 | One-cycle notice that translations changed |

## Verification
After every command, the bench sweeps lookups over a grid of addresses, partitions, real flags and contexts. It compares each result against a bench-side model of the slots.

Overlapping pages of different sizes check priority and offset merging. A wrong priority would return the larger page's address, and a wrong mask would corrupt the offset bits.

Filling the buffer and then inserting checks the replacement rules. A design that ignored lock flags would evict a locked slot. One that kept the pointer still would evict the same slot twice. One that wrote into a fully locked buffer would overwrite a pinned translation.

The demap commands are aimed at locked slots. Partition demap must leave them in place, while context and page demap must remove them. A bad reserved op code would show up as a stray flush pulse or a lost translation.

// File: rtl/tlb_fa_pkg.sv
`timescale 1ns/1ps
package tlb_fa_pkg;

  typedef enum logic [2:0] {
    OP_INSERT     = 3'd0,
    OP_DEMAP_PAGE = 3'd1,
    OP_DEMAP_CTX  = 3'd2,
    OP_DEMAP_PART = 3'd3,
    OP_INVAL_ALL  = 3'd4
  } tlbOp_e;

  typedef struct packed {
    logic insert;
    logic demapPage;
    logic demapCtx;
    logic demapPart;
    logic invalAll;
  } tlbStrobes_t;

  // Offset mask of a page whose size code is sizeCode.
  function automatic logic [63:0] pageMask(input int sizeCode, input int baseShift,
                                           input int shiftStep);
    int sh;
    sh = baseShift + shiftStep * sizeCode;
    if (sh >= 64) return '1;
    return (64'd1 << sh) - 64'd1;
  endfunction

endpackage

// File: rtl/tlb_fa_ctrl.sv
`timescale 1ns/1ps
module tlb_fa_ctrl
  import tlb_fa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output logic        cmdReady,
  output tlbStrobes_t strobes,
  output logic        flushPulse
);

  logic readyQ;
  logic accept;
  logic flushQ;

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= 1'b1;
  end

  assign accept   = cmdValid && readyQ;
  assign cmdReady = readyQ;

  always_comb begin
    strobes           = '0;
    strobes.insert    = accept && (cmdOp == OP_INSERT);
    strobes.demapPage = accept && (cmdOp == OP_DEMAP_PAGE);
    strobes.demapCtx  = accept && (cmdOp == OP_DEMAP_CTX);
    strobes.demapPart = accept && (cmdOp == OP_DEMAP_PART);
    strobes.invalAll  = accept && (cmdOp == OP_INVAL_ALL);
  end

  always_ff @(posedge clk) begin
    if (rst) flushQ <= 1'b0;
    else     flushQ <= |strobes;
  end

  assign flushPulse = flushQ;

endmodule

// File: rtl/tlb_fa_datapath.sv
`timescale 1ns/1ps
module tlb_fa_datapath
  import tlb_fa_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PART_W      = 4,
  parameter int CTX_W       = 8,
  parameter int SZ_W        = 2,
  parameter int BASE_SHIFT  = 12,
  parameter int SHIFT_STEP  = 3,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
)(
  input  logic              clk,
  input  logic              rst,
  input  tlbStrobes_t       strobes,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic              cmdLocked,
  input  logic [PA_W-1:0]   cmdPa,
  input  logic [SZ_W-1:0]   cmdSize,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic              lkReal,
  input  logic [CTX_W-1:0]  lkCtx,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIndex,
  output logic [PA_W-1:0]   lkPa,
  output logic              lkLocked,
  output logic [SZ_W-1:0]   lkSize
);

  logic [NUM_ENTRIES-1:0] entValid, entLocked, entReal;
  logic [PART_W-1:0]      entPart  [NUM_ENTRIES];
  logic [CTX_W-1:0]       entCtx   [NUM_ENTRIES];
  logic [VA_W-1:0]        entVBase [NUM_ENTRIES];
  logic [PA_W-1:0]        entPBase [NUM_ENTRIES];
  logic [SZ_W-1:0]        entSize  [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lkMatch, pgMatch, ctxMatch, partMatch, clearVec;
  logic [IDX_W-1:0]       rrPtr;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    logic [63:0] mask;
    assign mask = pageMask(int'(entSize[g]), BASE_SHIFT, SHIFT_STEP);
    assign lkMatch[g] = entValid[g] && (entPart[g] == lkPart) && (entReal[g] == lkReal) &&
                        (lkReal || (entCtx[g] == lkCtx)) &&
                        (((lkVa ^ entVBase[g]) & ~mask[VA_W-1:0]) == '0);
    assign pgMatch[g] = entValid[g] && (entPart[g] == cmdPart) && (entReal[g] == cmdReal) &&
                        (cmdReal || (entCtx[g] == cmdCtx)) &&
                        (((cmdVa ^ entVBase[g]) & ~mask[VA_W-1:0]) == '0);
    assign ctxMatch[g]  = entValid[g] && (entCtx[g] == cmdCtx) && (entPart[g] == cmdPart);
    assign partMatch[g] = (entPart[g] == cmdPart) && !entLocked[g];
    assign clearVec[g]  = strobes.invalAll || (strobes.demapPage && pgMatch[g]) ||
                          (strobes.demapCtx && ctxMatch[g]) || (strobes.demapPart && partMatch[g]);
  end

  // Lookup: lowest matching index wins.
  always_comb begin
    logic [63:0] hm;
    lkIndex = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) lkIndex = IDX_W'(i);
    end
    lkHit = |lkMatch;
    hm    = pageMask(int'(entSize[lkIndex]), BASE_SHIFT, SHIFT_STEP);
    if (lkHit) begin
      lkPa     = (entPBase[lkIndex] & ~hm[PA_W-1:0]) | (PA_W'(lkVa) & hm[PA_W-1:0]);
      lkLocked = entLocked[lkIndex];
      lkSize   = entSize[lkIndex];
    end else begin
      lkPa     = '0;
      lkLocked = 1'b0;
      lkSize   = '0;
    end
  end

  // Victim choice: first free slot, else first unlocked slot from the pointer.
  logic             freeFound, rrFound, wrEn;
  logic [IDX_W-1:0] freeIdx, rrIdx, wrIdx;

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    rrFound   = 1'b0;
    rrIdx     = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!entValid[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      int j;
      j = int'(rrPtr) + k;
      if (j >= NUM_ENTRIES) j = j - NUM_ENTRIES;
      if (!entLocked[j] && !rrFound) begin
        rrFound = 1'b1;
        rrIdx   = IDX_W'(j);
      end
    end
    wrIdx = freeFound ? freeIdx : rrIdx;
    wrEn  = strobes.insert && (freeFound || rrFound);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (clearVec[i])                         entValid[i] <= 1'b0;
        else if (wrEn && (wrIdx == IDX_W'(i)))   entValid[i] <= 1'b1;
      end
      if (wrEn && !freeFound)
        rrPtr <= (int'(rrIdx) == NUM_ENTRIES - 1) ? '0 : rrIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      entLocked[wrIdx] <= cmdLocked;
      entReal[wrIdx]   <= cmdReal;
      entPart[wrIdx]   <= cmdPart;
      entCtx[wrIdx]    <= cmdCtx;
      entVBase[wrIdx]  <= cmdVa;
      entPBase[wrIdx]  <= cmdPa;
      entSize[wrIdx]   <= cmdSize;
    end
  end

endmodule

// File: rtl/tlb_fa.sv
`timescale 1ns/1ps
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PART_W      = 4,
  parameter int CTX_W       = 8,
  parameter int SZ_W        = 2,
  parameter int BASE_SHIFT  = 12,
  parameter int SHIFT_STEP  = 3,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic              cmdLocked,
  input  logic [PA_W-1:0]   cmdPa,
  input  logic [SZ_W-1:0]   cmdSize,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic              lkReal,
  input  logic [CTX_W-1:0]  lkCtx,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIndex,
  output logic [PA_W-1:0]   lkPa,
  output logic              lkLocked,
  output logic [SZ_W-1:0]   lkSize,
  output logic              flushPulse
);

  if (NUM_ENTRIES < 2 || NUM_ENTRIES > 64) begin : g_badCfg
    $error("tlb_fa: NUM_ENTRIES must be between 2 and 64");
  end

  tlbStrobes_t strobes;

  tlb_fa_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdReady   (cmdReady),
    .strobes    (strobes),
    .flushPulse (flushPulse)
  );

  tlb_fa_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES), .VA_W (VA_W), .PA_W (PA_W), .PART_W (PART_W),
    .CTX_W (CTX_W), .SZ_W (SZ_W), .BASE_SHIFT (BASE_SHIFT), .SHIFT_STEP (SHIFT_STEP)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .cmdVa     (cmdVa),
    .cmdPart   (cmdPart),
    .cmdCtx    (cmdCtx),
    .cmdReal   (cmdReal),
    .cmdLocked (cmdLocked),
    .cmdPa     (cmdPa),
    .cmdSize   (cmdSize),
    .lkVa      (lkVa),
    .lkPart    (lkPart),
    .lkReal    (lkReal),
    .lkCtx     (lkCtx),
    .lkHit     (lkHit),
    .lkIndex   (lkIndex),
    .lkPa      (lkPa),
    .lkLocked  (lkLocked),
    .lkSize    (lkSize)
  );

endmodule

// File: rtl/tlb_fa_chk.sv
`timescale 1ns/1ps
module tlb_fa_chk #(
  parameter int PART_W = 4,
  parameter int CTX_W  = 8
)(
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [2:0]        cmdOp,
  input logic [PART_W-1:0] cmdPart,
  input logic [CTX_W-1:0]  cmdCtx,
  input logic [PART_W-1:0] lkPart,
  input logic              lkReal,
  input logic [CTX_W-1:0]  lkCtx,
  input logic              lkHit,
  input logic              lkLocked,
  input logic              flushPulse
);

  logic              takeMod;
  logic [2:0]        opQ;
  logic [PART_W-1:0] partQ;
  logic [CTX_W-1:0]  ctxQ;

  assign takeMod = cmdValid && cmdReady && (cmdOp <= 3'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      opQ   <= 3'd7;
      partQ <= '0;
      ctxQ  <= '0;
    end else if (cmdValid && cmdReady) begin
      opQ   <= cmdOp;
      partQ <= cmdPart;
      ctxQ  <= cmdCtx;
    end
  end

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cmdReady);

  p_flush_after_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    takeMod |=> flushPulse);

  // Also covers R11: reserved codes must not pulse.
  p_no_stray_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !takeMod |=> !flushPulse);

  p_inval_all_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (flushPulse && opQ == 3'd4) |-> !lkHit);

  p_part_demap_spares_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (flushPulse && opQ == 3'd3 && lkHit && lkPart == partQ) |-> lkLocked);

  p_ctx_demap_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (flushPulse && opQ == 3'd2 && !lkReal && lkPart == partQ && lkCtx == ctxQ) |-> !lkHit);

endmodule

bind tlb_fa tlb_fa_chk #(.PART_W(PART_W), .CTX_W(CTX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdOp      (cmdOp),
  .cmdPart    (cmdPart),
  .cmdCtx     (cmdCtx),
  .lkPart     (lkPart),
  .lkReal     (lkReal),
  .lkCtx      (lkCtx),
  .lkHit      (lkHit),
  .lkLocked   (lkLocked),
  .flushPulse (flushPulse)
);

// File: tb/tlb_fa_bench.sv
`timescale 1ns/1ps
module tlb_fa_bench;

  localparam int N      = 4;
  localparam int VA_W   = 12;
  localparam int PA_W   = 12;
  localparam int PART_W = 2;
  localparam int CTX_W  = 3;
  localparam int SZ_W   = 2;
  localparam int BSH    = 4;
  localparam int STP    = 2;
  localparam int IDX_W  = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              cmdValid = 1'b0, cmdReady, cmdReal = 1'b0, cmdLocked = 1'b0;
  logic [2:0]        cmdOp = '0;
  logic [VA_W-1:0]   cmdVa = '0;
  logic [PART_W-1:0] cmdPart = '0;
  logic [CTX_W-1:0]  cmdCtx = '0;
  logic [PA_W-1:0]   cmdPa = '0;
  logic [SZ_W-1:0]   cmdSize = '0;
  logic [VA_W-1:0]   lkVa = '0;
  logic [PART_W-1:0] lkPart = '0;
  logic              lkReal = 1'b0;
  logic [CTX_W-1:0]  lkCtx = '0;
  logic              lkHit, lkLocked, flushPulse;
  logic [IDX_W-1:0]  lkIndex;
  logic [PA_W-1:0]   lkPa;
  logic [SZ_W-1:0]   lkSize;

  tlb_fa #(.NUM_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .PART_W(PART_W), .CTX_W(CTX_W),
           .SZ_W(SZ_W), .BASE_SHIFT(BSH), .SHIFT_STEP(STP)) u_tlb_fa (.*);

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // Bench-side model of the slots.
  bit mValid[N], mLocked[N], mReal[N];
  int mPart[N], mCtx[N], mVa[N], mPa[N], mSize[N];
  int mPtr = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int maskOf(input int sz);
    return (1 << (BSH + STP * sz)) - 1;
  endfunction

  function automatic bit mHits(input int i, input int va, input int part, input bit rl, input int ctx);
    return mValid[i] && mPart[i] == part && mReal[i] == rl && (rl || mCtx[i] == ctx) &&
           ((va & ~maskOf(mSize[i])) == (mVa[i] & ~maskOf(mSize[i])));
  endfunction

  task automatic sweep(input string tag);
    for (int va = 0; va < 'h400; va += 'h10) begin
      for (int p = 0; p < 3; p++) begin
        for (int r = 0; r < 2; r++) begin
          for (int c = 2; c < 5; c++) begin
            int ei;
            int epa;
            ei = -1;
            for (int i = N - 1; i >= 0; i--) if (mHits(i, va + 8, p, r[0], c)) ei = i;
            @(negedge clk);
            lkVa = VA_W'(va + 8); lkPart = PART_W'(p); lkReal = r[0]; lkCtx = CTX_W'(c);
            #1;
            if (ei < 0) begin
              check(lkHit == 1'b0, {tag, " miss"}, int'(lkHit), 0);
            end else begin
              epa = ((mPa[ei] & ~maskOf(mSize[ei])) | ((va + 8) & maskOf(mSize[ei]))) & 'hFFF;
              check(lkHit && int'(lkIndex) == ei && int'(lkPa) == epa &&
                    lkLocked == mLocked[ei] && int'(lkSize) == mSize[ei],
                    {tag, " hit idx/pa"}, (int'(lkIndex) << 16) | int'(lkPa), (ei << 16) | epa);
            end
          end
        end
      end
    end
  endtask

  task automatic modelInsert(input int va, input int part, input int ctx, input bit rl,
                             input bit lk, input int pa, input int sz);
    int w;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (!mValid[i]) w = i;
    if (w < 0) begin
      for (int k = N - 1; k >= 0; k--) if (!mLocked[(mPtr + k) % N]) w = (mPtr + k) % N;
      if (w >= 0) mPtr = (w + 1) % N;
    end
    if (w >= 0) begin
      mValid[w] = 1; mLocked[w] = lk; mReal[w] = rl; mPart[w] = part;
      mCtx[w] = ctx; mVa[w] = va; mPa[w] = pa; mSize[w] = sz;
    end
  endtask

  task automatic doCmd(input int op, input int va, input int part, input int ctx, input bit rl,
                       input bit lk, input int pa, input int sz, input string tag);
    @(negedge clk);
    cmdOp = 3'(op); cmdVa = VA_W'(va); cmdPart = PART_W'(part); cmdCtx = CTX_W'(ctx);
    cmdReal = rl; cmdLocked = lk; cmdPa = PA_W'(pa); cmdSize = SZ_W'(sz); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(flushPulse == (op <= 4), {tag, " R10 flush high after cmd"}, int'(flushPulse), int'(op <= 4));
    case (op)
      0: modelInsert(va, part, ctx, rl, lk, pa, sz);
      1: for (int i = 0; i < N; i++) if (mHits(i, va, part, rl, ctx)) mValid[i] = 0;
      2: for (int i = 0; i < N; i++) if (mValid[i] && mCtx[i] == ctx && mPart[i] == part) mValid[i] = 0;
      3: for (int i = 0; i < N; i++) if (mPart[i] == part && !mLocked[i]) mValid[i] = 0;
      4: for (int i = 0; i < N; i++) mValid[i] = 0;
      default: ;
    endcase
    @(negedge clk);
    check(flushPulse == 1'b0, {tag, " R10 flush one cycle"}, int'(flushPulse), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b0, "R1 ready low in reset", int'(cmdReady), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmdReady == 1'b1, "R1 ready after reset", int'(cmdReady), 1);
    sweep("R1 empty after reset");

    // R4 fill free slots in order; R2/R3 overlap and offsets.
    doCmd(0, 'h100, 1, 2, 0, 0, 'hA00, 0, "R4 insA");
    doCmd(0, 'h200, 1, 5, 1, 1, 'hB40, 1, "R4 insB");
    doCmd(0, 'h100, 2, 3, 0, 0, 'hC00, 2, "R4 insC");
    doCmd(0, 'h150, 1, 2, 0, 0, 'h700, 2, "R4 insD");
    sweep("R2 R3 R4 filled");

    // R5 replacement when full.
    doCmd(0, 'h300, 0, 0, 0, 0, 'h000, 1, "R5 insE");
    sweep("R5 after first victim");
    doCmd(0, 'h040, 1, 2, 0, 1, 'h880, 0, "R5 insF");
    sweep("R5 pointer skips locked");

    doCmd(1, 'h1F0, 1, 2, 0, 0, 0, 0, "R6 page demap");
    sweep("R6 after page demap");
    doCmd(0, 'h3C0, 1, 4, 0, 0, 'h5C0, 0, "R4 refill");
    sweep("R4 refill free slot");

    doCmd(2, 0, 1, 2, 0, 0, 0, 0, "R7 ctx demap");
    sweep("R7 after ctx demap");
    doCmd(0, 'h080, 1, 4, 0, 1, 'h990, 1, "R4 insH");
    doCmd(3, 0, 1, 0, 0, 0, 0, 0, "R8 part demap");
    sweep("R8 locked survive");

    doCmd(5, 'h3C0, 0, 0, 0, 0, 0, 0, "R11 reserved op");
    doCmd(7, 0, 1, 0, 0, 0, 0, 0, "R11 reserved op");
    sweep("R11 no change");

    doCmd(4, 0, 0, 0, 0, 0, 0, 0, "R9 inval all");
    sweep("R9 all cleared");

    for (int i = 0; i < N; i++) doCmd(0, 'h40 * i, 2, 3, 0, 1, 'h400 + 'h40 * i, 1, "R4 locked fill");
    doCmd(0, 'h300, 2, 3, 0, 0, 'hF00, 0, "R5 all locked");
    sweep("R5 all locked insert dropped");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule